// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single sixteen-bit down-counting timer channel, programmed through a byte-wide port. A control write carries a two-bit channel select, and the channel acts on it only when that select equals its fixed index. The control byte picks one of three byte-access orders, one of six output waveforms, and binary or four-digit BCD counting. The same select with an access code of zero is a latch command. It freezes the live count so that a two-byte read cannot tear. Count values are written and read through one 8-bit data port.

The counting clock is a one-cycle enable, `cnt_tick`, in the system clock domain. Each tick is one counting-clock pulse. `gate` either holds the count or triggers it, depending on the mode, and `out` is the registered waveform. A typical use sets mode 0 with a count of 11931 against a 1,193,182 Hz tick, then polls `out` until it rises about 10 ms later.

Control byte layout: bits 7-6 are the channel select, bits 5-4 the access code, bits 3-1 the mode and bit 0 the BCD flag. Mode codes 110 and 111 act as 010 and 011.

Top module: `pit_channel`

## Requirements
- R1: A control byte whose bits 7-6 differ from parameter CH_IDX changes no state. With the default index 2, bytes with select 00 or 01 have no effect on `out`, the mode or the count.
- R2: Access code bits 5-4: 01 moves the low byte only (the high byte is written as zero), 10 moves the high byte only (the low byte is written as zero), 11 moves the low byte then the high byte. Writes and reads use the same order.
- R3: Access code 00 copies the live count into a hold register. Reads return the held value until every byte of the current access order has been read. A second latch command issued while a value is held is ignored.
- R4: With bit 0 set, the count decrements as four BCD digits, so 0x0100 becomes 0x0099. A written count of zero counts as 65536 in binary and 10000 in BCD: one tick after loading it, the count reads 0xFFFF or 0x9999.
- R5: Mode 0: the control write and each completed count write drive `out` low. The count loads on the first tick after the count is written. After that each tick with `gate` high decrements it, and `out` goes high when the count reaches zero. A count of N therefore raises `out` on tick N+1, and `out` stays high until the channel is reprogrammed.
- R6: In modes 0, 2, 3 and 4, a tick while `gate` is low leaves the count unchanged. The mode 0 and mode 4 load still takes place.
- R7: Mode 1: a rising `gate` arms a load at the next tick, which drives `out` low. `out` returns high when the count reaches zero, so it is low for N ticks. A new rising edge reloads the full count.
- R8: Mode 2 with N of at least 2: `out` is low for the single tick period in which the count is 1. The next tick reloads N and raises `out`, giving a period of N ticks.
- R9: Mode 3 with N of at least 2: `out` is high for ceil(N/2) ticks and low for floor(N/2) ticks. In modes 2 and 3 a low `gate` forces `out` high on the next clock, and a rising `gate` restarts from a fresh load.
- R10: Mode 4: `out` is high after programming. When the count reaches zero, `out` drops low for exactly one tick period. This happens once per count write.
- R11: Mode 5: a rising `gate` arms a load at the next tick with `out` high. Reaching zero then gives the same one-tick low strobe as in mode 4.
- R12: `dout` is registered and changes only in the cycle after `rd_data`. Reset sets `out` and `dout` to zero.
- R13: An accepted control byte with a nonzero mode drives `out` high on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_ctl | input | 1 | Strobe: `din` holds a control byte |
| wr_data | input | 1 | Strobe: `din` holds a count byte |
| rd_data | input | 1 | Strobe: read the next count byte |
| din | input | 8 | Write data |
| cnt_tick | input | 1 | One-cycle counting-clock pulse |
| gate | input | 1 | Count enable or trigger, per mode |
| dout | output | 8 | Read data, valid the cycle after `rd_data` |
| out | output | 1 | Timer waveform output |

## Verification
The checker holds the following on every cycle:
- foreign control bytes leave the mode unchanged;
- an accepted control byte sets `out` to its programmed level;
- the count moves only on a tick, and never on a gated-off tick;
- the mode 2, 4 and 5 low phases last exactly one tick;
- `dout` holds still between reads.

Only the bench scenarios can show the rest:
- the tick on which each mode's edges fall;
- BCD digit borrow and the zero-means-maximum wrap;
- latch ordering across two-byte reads;
- retriggering in mode 1;
- the ten-millisecond terminal count.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int PIT_DIGITS = 4;
  localparam int BYTE_W     = 8;
  localparam int CNT_W      = 2 * BYTE_W;

  typedef enum logic [2:0] {
    M_TCOUNT   = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } pit_mode_e;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_LOHI  = 2'd3
  } pit_acc_e;

  typedef struct packed {
    pit_acc_e  acc;
    pit_mode_e mode;
    logic      bcd;
  } pit_cfg_t;
endpackage

// File: rtl/pit_bcd_dec.sv
// Count minus one, binary or BCD; zero wraps to all ones / all nines.
module pit_bcd_dec #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] val,
  input  logic                bcd,
  output logic [4*DIGITS-1:0] minus1
);
  localparam int W = 4 * DIGITS;

  logic [DIGITS-1:0] brw;
  logic [W-1:0]      bcd_res;

  assign brw[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [3:0] d;
    assign d = val[4*g +: 4];
    assign bcd_res[4*g +: 4] = !brw[g] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
    if (g < DIGITS - 1) begin : g_chain
      assign brw[g+1] = brw[g] & (d == 4'd0);
    end
  end

  assign minus1 = bcd ? bcd_res : val - W'(1);
endmodule

// File: rtl/pit_half.sv
// floor(val/2) in binary or BCD; zero stands for the maximum count.
module pit_half #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] val,
  input  logic                bcd,
  output logic [4*DIGITS-1:0] half
);
  localparam int W = 4 * DIGITS;
  localparam logic [W-1:0] HALF_BIN = W'(1) << (W - 1);
  localparam logic [W-1:0] HALF_BCD = W'(5) << (W - 4);

  logic [W-1:0] bcd_res;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [3:0] d;
    logic       up_odd;
    assign d = val[4*g +: 4];
    if (g == DIGITS - 1) begin : g_top
      assign up_odd = 1'b0;
    end else begin : g_low
      assign up_odd = val[4*(g+1)];
    end
    assign bcd_res[4*g +: 4] = {1'b0, d[3:1]} + (up_odd ? 4'd5 : 4'd0);
  end

  always_comb begin
    if (val == '0)
      half = bcd ? HALF_BCD : HALF_BIN;
    else
      half = bcd ? bcd_res : (val >> 1);
  end
endmodule

// File: rtl/pit_port.sv
// Control decode, count register, latch and byte sequencing.
module pit_port
  import pit_pkg::*;
#(
  parameter logic [1:0] CH_IDX = 2'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctl,
  input  logic              wr_data,
  input  logic              rd_data,
  input  logic [BYTE_W-1:0] din,
  input  logic [CNT_W-1:0]  live,
  output pit_mode_e         mode,
  output logic              bcd,
  output logic [CNT_W-1:0]  cr,
  output logic              ctl_hit,
  output pit_mode_e         ctl_mode,
  output logic              cnt_done,
  output logic [BYTE_W-1:0] dout
);
  pit_cfg_t            cfg;
  logic                wr_hi, rd_hi, latched;
  logic [CNT_W-1:0]    hold;
  logic [CNT_W-1:0]    src;
  logic                sel_ok, latch_cmd;
  logic [2:0]          mbits;

  assign sel_ok    = (din[7:6] == CH_IDX);
  assign ctl_hit   = wr_ctl && sel_ok && (din[5:4] != 2'b00);
  assign latch_cmd = wr_ctl && sel_ok && (din[5:4] == 2'b00);
  assign mbits     = din[3:1];
  assign ctl_mode  = mbits[1] ? pit_mode_e'({1'b0, mbits[1:0]}) : pit_mode_e'(mbits);
  assign cnt_done  = wr_data && ((cfg.acc != ACC_LOHI) || wr_hi);
  assign src       = latched ? hold : live;
  assign mode      = cfg.mode;
  assign bcd       = cfg.bcd;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '{acc: ACC_LOHI, mode: M_TCOUNT, bcd: 1'b0};
      cr      <= '0;
      hold    <= '0;
      wr_hi   <= 1'b0;
      rd_hi   <= 1'b0;
      latched <= 1'b0;
      dout    <= '0;
    end else begin
      if (ctl_hit) begin
        cfg     <= '{acc: pit_acc_e'(din[5:4]), mode: ctl_mode, bcd: din[0]};
        wr_hi   <= 1'b0;
        rd_hi   <= 1'b0;
        latched <= 1'b0;
      end
      if (latch_cmd && !latched) begin
        hold    <= live;
        latched <= 1'b1;
      end
      if (wr_data) begin
        case (cfg.acc)
          ACC_LO: cr <= {{BYTE_W{1'b0}}, din};
          ACC_HI: cr <= {din, {BYTE_W{1'b0}}};
          ACC_LOHI: begin
            if (!wr_hi) cr[BYTE_W-1:0] <= din;
            else        cr[CNT_W-1:BYTE_W] <= din;
            wr_hi <= !wr_hi;
          end
          default: ;
        endcase
      end
      if (rd_data) begin
        case (cfg.acc)
          ACC_LO: begin
            dout    <= src[BYTE_W-1:0];
            latched <= 1'b0;
          end
          ACC_HI: begin
            dout    <= src[CNT_W-1:BYTE_W];
            latched <= 1'b0;
          end
          ACC_LOHI: begin
            if (!rd_hi) begin
              dout <= src[BYTE_W-1:0];
            end else begin
              dout    <= src[CNT_W-1:BYTE_W];
              latched <= 1'b0;
            end
            rd_hi <= !rd_hi;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pit_core.sv
// Counting element and output waveform for all six modes.
module pit_core
  import pit_pkg::*;
#(
  parameter int DIGITS = PIT_DIGITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                gate,
  input  pit_mode_e           mode,
  input  logic                bcd,
  input  logic [4*DIGITS-1:0] cr,
  input  logic                cnt_done,
  input  logic                ctl_hit,
  input  pit_mode_e           ctl_mode,
  output logic [4*DIGITS-1:0] count,
  output logic                out,
  output logic                pend
);
  localparam int W = 4 * DIGITS;

  logic [W-1:0] dec, cr_half;
  logic         have, run, trig, extra, armed, gate_q, rise, at_one;

  pit_bcd_dec #(.DIGITS(DIGITS)) u_dec  (.val(count), .bcd(bcd), .minus1(dec));
  pit_half    #(.DIGITS(DIGITS)) u_half (.val(cr),    .bcd(bcd), .half(cr_half));

  assign rise   = gate && !gate_q;
  assign at_one = (count == W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      out    <= 1'b0;
      pend   <= 1'b0;
      have   <= 1'b0;
      run    <= 1'b0;
      trig   <= 1'b0;
      extra  <= 1'b0;
      armed  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (ctl_hit) begin
        out   <= (ctl_mode != M_TCOUNT);
        pend  <= 1'b0;
        have  <= 1'b0;
        run   <= 1'b0;
        trig  <= 1'b0;
        extra <= 1'b0;
        armed <= 1'b0;
      end else begin
        if (tick) begin
          case (mode)
            M_TCOUNT, M_SWSTROBE: begin
              if (mode == M_SWSTROBE && !out) out <= 1'b1;
              if (pend) begin
                count <= cr;
                pend  <= 1'b0;
                run   <= 1'b1;
                armed <= 1'b1;
              end else if (run && gate) begin
                count <= dec;
                if (at_one) begin
                  if (mode == M_TCOUNT) out <= 1'b1;
                  else if (armed) begin
                    out   <= 1'b0;
                    armed <= 1'b0;
                  end
                end
              end
            end
            M_ONESHOT, M_HWSTROBE: begin
              if (mode == M_HWSTROBE && !out) out <= 1'b1;
              trig <= 1'b0;
              if (trig && have) begin
                count <= cr;
                run   <= 1'b1;
                armed <= 1'b1;
                out   <= (mode == M_HWSTROBE);
              end else if (run) begin
                count <= dec;
                if (at_one) begin
                  if (mode == M_ONESHOT) out <= 1'b1;
                  else if (armed) begin
                    out   <= 1'b0;
                    armed <= 1'b0;
                  end
                end
              end
            end
            M_RATE: begin
              if (gate) begin
                if ((pend || trig) && have) begin
                  count <= cr;
                  out   <= 1'b1;
                  pend  <= 1'b0;
                  trig  <= 1'b0;
                  run   <= 1'b1;
                end else if (run) begin
                  if (at_one) begin
                    count <= cr;
                    out   <= 1'b1;
                  end else begin
                    count <= dec;
                    if (count == W'(2)) out <= 1'b0;
                  end
                end
              end
            end
            M_SQUARE: begin
              if (gate) begin
                if ((pend || trig) && have) begin
                  count <= cr_half;
                  extra <= cr[0];
                  out   <= 1'b1;
                  pend  <= 1'b0;
                  trig  <= 1'b0;
                  run   <= 1'b1;
                end else if (run) begin
                  if (at_one) begin
                    if (extra) begin
                      extra <= 1'b0;
                    end else begin
                      out   <= !out;
                      count <= cr_half;
                      extra <= !out ? cr[0] : 1'b0;
                    end
                  end else begin
                    count <= dec;
                  end
                end
              end
            end
            default: ;
          endcase
        end
        if (rise) trig <= 1'b1;
        if (cnt_done) begin
          have <= 1'b1;
          case (mode)
            M_TCOUNT: begin
              out  <= 1'b0;
              pend <= 1'b1;
            end
            M_SWSTROBE:       pend <= 1'b1;
            M_RATE, M_SQUARE: if (!run) pend <= 1'b1;
            default: ;
          endcase
        end
        if ((mode == M_RATE || mode == M_SQUARE) && !gate) out <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter logic [1:0] CH_IDX = 2'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctl,
  input  logic              wr_data,
  input  logic              rd_data,
  input  logic [BYTE_W-1:0] din,
  input  logic              cnt_tick,
  input  logic              gate,
  output logic [BYTE_W-1:0] dout,
  output logic              out
);
  pit_mode_e        cur_mode, ctl_mode;
  logic             bcd, ctl_hit, cnt_done, load_pend;
  logic [CNT_W-1:0] cr, live_count;

  pit_port #(.CH_IDX(CH_IDX)) u_port (
    .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .wr_data(wr_data), .rd_data(rd_data),
    .din(din), .live(live_count), .mode(cur_mode), .bcd(bcd), .cr(cr),
    .ctl_hit(ctl_hit), .ctl_mode(ctl_mode), .cnt_done(cnt_done), .dout(dout)
  );

  pit_core #(.DIGITS(PIT_DIGITS)) u_core (
    .clk(clk), .rst(rst), .tick(cnt_tick), .gate(gate), .mode(cur_mode),
    .bcd(bcd), .cr(cr), .cnt_done(cnt_done), .ctl_hit(ctl_hit),
    .ctl_mode(ctl_mode), .count(live_count), .out(out), .pend(load_pend)
  );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
#(
  parameter logic [1:0] CH_IDX = 2'd2
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_ctl,
  input logic             rd_data,
  input logic [7:0]       din,
  input logic             cnt_tick,
  input logic             gate,
  input logic             out,
  input logic [7:0]       dout,
  input pit_mode_e        cur_mode,
  input logic [CNT_W-1:0] live_count,
  input logic             load_pend
);
  logic accept, gated_mode;
  assign accept     = wr_ctl && (din[7:6] == CH_IDX) && (din[5:4] != 2'b00);
  assign gated_mode = (cur_mode == M_TCOUNT) || (cur_mode == M_RATE) ||
                      (cur_mode == M_SQUARE) || (cur_mode == M_SWSTROBE);

  assert_foreign_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && din[7:6] != CH_IDX) |=> $stable(cur_mode));

  assert_mode0_low_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && din[3:1] == 3'b000) |=> !out);

  assert_count_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    !cnt_tick |=> $stable(live_count));

  assert_gate_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick && !gate && gated_mode && !load_pend) |=> $stable(live_count));

  assert_rate_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == M_RATE && !out && cnt_tick && !accept) |=> out);

  assert_strobe_width_R10: assert property (@(posedge clk) disable iff (rst)
    ((cur_mode == M_SWSTROBE || cur_mode == M_HWSTROBE) && !out && cnt_tick && !accept) |=> out);

  assert_dout_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_data |=> $stable(dout));

  assert_ctl_high_R13: assert property (@(posedge clk) disable iff (rst)
    (accept && din[3:1] != 3'b000) |=> out);
endmodule

bind pit_channel pit_channel_chk #(.CH_IDX(CH_IDX)) u_chk (
  .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .rd_data(rd_data), .din(din),
  .cnt_tick(cnt_tick), .gate(gate), .out(out), .dout(dout),
  .cur_mode(cur_mode), .live_count(live_count), .load_pend(load_pend)
);

// File: tb/sim_pit_channel.sv
module sim_pit_channel;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;
  // {control byte, count, ticks after writing, expected out}
  localparam logic [40:0] VEC [NVEC] = '{
    {8'hB0, 16'd3,      16'd0,     1'b0},
    {8'hB0, 16'd3,      16'd3,     1'b0},
    {8'hB0, 16'd3,      16'd4,     1'b1},
    {8'hB1, 16'h0010,   16'd10,    1'b0},
    {8'hB1, 16'h0010,   16'd11,    1'b1},
    {8'hB4, 16'd3,      16'd3,     1'b0},
    {8'hB4, 16'd3,      16'd4,     1'b1},
    {8'hB6, 16'd5,      16'd3,     1'b1},
    {8'hB6, 16'd5,      16'd4,     1'b0},
    {8'hB6, 16'd5,      16'd6,     1'b1},
    {8'hB8, 16'd2,      16'd2,     1'b1},
    {8'hB8, 16'd2,      16'd3,     1'b0},
    {8'hB8, 16'd2,      16'd4,     1'b1},
    {8'hB0, 16'd11931,  16'd11931, 1'b0},
    {8'hB0, 16'd11931,  16'd11932, 1'b1}
  };

  logic       clk = 1'b0, rst = 1'b1;
  logic       wr_ctl = 1'b0, wr_data = 1'b0, rd_data = 1'b0, cnt_tick = 1'b0, gate = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       out;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  pit_channel u0 (.clk(clk), .rst(rst), .wr_ctl(wr_ctl), .wr_data(wr_data),
                  .rd_data(rd_data), .din(din), .cnt_tick(cnt_tick), .gate(gate),
                  .dout(dout), .out(out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic put_ctl(input logic [7:0] b);
    wr_ctl = 1'b1; din = b; @(negedge clk); wr_ctl = 1'b0;
  endtask
  task automatic put_dat(input logic [7:0] b);
    wr_data = 1'b1; din = b; @(negedge clk); wr_data = 1'b0;
  endtask
  task automatic put_cnt(input logic [15:0] v);
    put_dat(v[7:0]); put_dat(v[15:8]);
  endtask
  task automatic ticks(input int n);
    cnt_tick = 1'b1; repeat (n) @(negedge clk); cnt_tick = 1'b0;
  endtask
  task automatic rd_byte(output logic [7:0] v);
    rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; v = dout;
  endtask
  task automatic pulse_gate();
    gate = 1'b0; @(negedge clk); gate = 1'b1; @(negedge clk);
  endtask

  function automatic string tag_of(input logic [7:0] c);
    case (c[3:1])
      3'd0:    return c[0] ? "R4" : "R5";
      3'd2:    return "R8";
      3'd3:    return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] lo, hi;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 reset out", 16'(out), 16'd0);
    chk("R12 reset dout", 16'(dout), 16'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [7:0]  c;
      logic [15:0] v, n;
      logic        e;
      {c, v, n, e} = VEC[i];
      put_ctl(c);
      put_cnt(v);
      if (n != 0) ticks(int'(n));
      chk(tag_of(c), 16'(out), 16'(e));
    end

    // R1: foreign channel select
    put_ctl(8'hB0); put_cnt(16'd1); ticks(2);
    chk("R1 setup", 16'(out), 16'd1);
    put_ctl(8'h30); @(negedge clk);
    chk("R1 sel 00", 16'(out), 16'd1);
    put_ctl(8'h74); @(negedge clk);
    chk("R1 sel 01", 16'(out), 16'd1);

    // R6: gate low holds mode 0
    put_ctl(8'hB0); gate = 1'b0; put_cnt(16'd4); ticks(5);
    chk("R6 held out", 16'(out), 16'd0);
    rd_byte(lo); rd_byte(hi);
    chk("R6 held count", {hi, lo}, 16'd4);
    gate = 1'b1; ticks(3);
    chk("R6 resumed", 16'(out), 16'd0);
    ticks(1);
    chk("R6 terminal", 16'(out), 16'd1);

    // R3: latch
    put_ctl(8'hB0); put_cnt(16'h1234); ticks(3);
    put_ctl(8'h80); ticks(3);
    rd_byte(lo); chk("R3 latched lo", 16'(lo), 16'h32);
    rd_byte(hi); chk("R3 latched hi", 16'(hi), 16'h12);
    rd_byte(lo); chk("R3 live lo", 16'(lo), 16'h2F);
    rd_byte(hi); chk("R3 live hi", 16'(hi), 16'h12);
    put_ctl(8'h80); ticks(1); put_ctl(8'h80);
    rd_byte(lo); rd_byte(hi);
    chk("R3 second latch ignored", {hi, lo}, 16'h122F);

    // R4: zero as maximum, BCD borrow
    put_ctl(8'hB0); put_cnt(16'h0000); ticks(2);
    rd_byte(lo); rd_byte(hi);
    chk("R4 binary max", {hi, lo}, 16'hFFFF);
    put_ctl(8'hB1); put_cnt(16'h0000); ticks(2);
    rd_byte(lo); rd_byte(hi);
    chk("R4 bcd max", {hi, lo}, 16'h9999);
    put_ctl(8'hB1); put_cnt(16'h0100); ticks(2);
    rd_byte(lo); rd_byte(hi);
    chk("R4 bcd borrow", {hi, lo}, 16'h0099);

    // R2: single-byte access orders
    put_ctl(8'h90); put_dat(8'h07); ticks(1);
    rd_byte(lo); chk("R2 low only", 16'(lo), 16'h07);
    rd_byte(lo); chk("R2 low only repeat", 16'(lo), 16'h07);
    put_ctl(8'hA0); put_dat(8'h01); ticks(1);
    rd_byte(hi); chk("R2 high only", 16'(hi), 16'h01);
    put_ctl(8'h80); rd_byte(lo);
    chk("R2 high only no low", 16'(lo), 16'h01);

    // R7 / R13: mode 1 with retrigger
    gate = 1'b0; put_ctl(8'hB2); put_cnt(16'd3);
    chk("R13 mode1 idle high", 16'(out), 16'd1);
    gate = 1'b1; @(negedge clk); ticks(1);
    chk("R7 trigger low", 16'(out), 16'd0);
    ticks(1); pulse_gate(); ticks(1);
    ticks(2);
    chk("R7 retrigger still low", 16'(out), 16'd0);
    ticks(1);
    chk("R7 end high", 16'(out), 16'd1);

    // R11: mode 5
    put_ctl(8'hBA); put_cnt(16'd2); pulse_gate(); ticks(1);
    chk("R11 loaded high", 16'(out), 16'd1);
    ticks(1); chk("R11 before zero", 16'(out), 16'd1);
    ticks(1); chk("R11 strobe", 16'(out), 16'd0);
    ticks(1); chk("R11 after strobe", 16'(out), 16'd1);

    // R9: gate in square wave
    put_ctl(8'hB6); put_cnt(16'd4); ticks(3);
    chk("R9 low half", 16'(out), 16'd0);
    gate = 1'b0; @(negedge clk);
    chk("R9 gate forces high", 16'(out), 16'd1);
    gate = 1'b1; @(negedge clk); ticks(1);
    chk("R9 restart high", 16'(out), 16'd1);
    ticks(2);
    chk("R9 restart low", 16'(out), 16'd0);

    finish_run();
  end
endmodule